// File: doc/BRIEF.md
# USB Bus State Event Monitor

This block observes the sampled line state of a full-speed transceiver and turns long stretches of particular line conditions into bus events. A bus reset is a long single-ended zero. Suspend is a long idle (J) period. Resume is the return of activity after suspend. A turnaround timeout means the host did not answer within a fixed number of bit times after the device finished sending. The four conditions form one read-only status word. Any of them raises a single sticky interrupt flag, which software clears by writing 1, and which reaches the interrupt line only while the enable input is high.

The block also registers two drive requests for the transmitter. One asks for the K state during remote wakeup. The other asks for both lines to be driven low. All thresholds are parameters counted in clock cycles. The turnaround window is derived from the number of clocks per full-speed bit.

Top module: `usb_bus_monitor`

## Requirements
- R1: The bus-reset status (status bit 0) goes to 1 once the sampled line has been SE0 (line_i = 2'b00) for RST_CYC consecutive cycles. It returns to 0 within three cycles after the line leaves SE0.
- R2: The suspend status (status bit 1) goes to 1 once the line has been J (line_i = 2'b01) for SUSP_CYC consecutive cycles. It returns to 0 within three cycles after any non-J state (K = 2'b10, SE1 = 2'b11 or SE0).
- R3: The resume status (status bit 2) goes to 1 when suspend ends. It stays 1 until suspend is entered again or a bus reset is detected.
- R4: After a pkt_end pulse, the timeout status (status bit 3) goes to 1 if the line stays J for CLK_PER_BIT*TOUT_BITS cycles. Any non-J state before that cancels the wait. The next pkt_end pulse clears the bit.
- R5: The sticky flag evt_flag is set on every 0-to-1 change of any status bit. It holds until it is cleared.
- R6: A one-cycle flag_clr pulse clears evt_flag and does not change the status bits. A new event in the same cycle wins over the clear.
- R7: irq equals evt_flag AND irq_en.
- R8: drive_k is 1 one cycle after rwake is 1 while force_se0 is 0. Otherwise drive_k is 0.
- R9: drive_se0 follows force_se0 one cycle later. drive_se0 and drive_k are never both 1.
- R10: After reset, the status, evt_flag, irq and both drive outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 2 | Line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| pkt_end | input | 1 | Pulse at the end of the device's own packet |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-1 strobe that clears the sticky flag |
| rwake | input | 1 | Remote-wakeup control |
| force_se0 | input | 1 | Force-SE0 control |
| status | output | 4 | {timeout, resume, suspend, bus reset} |
| evt_flag | output | 1 | Sticky bus-event flag |
| irq | output | 1 | Gated interrupt |
| drive_k | output | 1 | Request to drive K |
| drive_se0 | output | 1 | Request to drive SE0 |

## Verification
The assertions check every cycle that the flag holds without a clear and sets after any event, and that the timers never run past their limits. They also check that suspend drops after non-J activity, that resume follows the end of suspend, that a new packet end clears the timeout, and that the two drive requests are exclusive. Only the bench scenarios show the threshold boundaries themselves: no reset just below RST_CYC, and no timeout when the host answers early. Only they show that the status bits survive a flag clear, and how the enable gates the interrupt.

// File: rtl/usb_mon_pkg.sv
package usb_mon_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef struct packed {
    logic tout;
    logic resume;
    logic suspend;
    logic bus_rst;
  } bus_sts_t;

  localparam int NUM_EVT = 4;
endpackage

// File: rtl/usb_rst_sync.sv
module usb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shr <= '0;
    else        shr <= {shr[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shr[STAGES-1];
endmodule

// File: rtl/usb_run_timer.sv
module usb_run_timer #(
  parameter int LIMIT = 8,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic hit
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          at_lim;

  assign at_lim = (cnt_q == CW'(LIMIT));

  always_comb begin
    cnt_n = cnt_q;
    if (!run || restart) cnt_n = '0;
    else if (!at_lim)    cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign hit = at_lim;

  // R1 R2 R4: the shared window counter saturates and never wraps
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));
  p_hit_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !hit);
endmodule

// File: rtl/usb_evt_flag.sv
module usb_evt_flag #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic         clr,
  output logic         flag
);
  logic [N-1:0] lvl_q;
  logic [N-1:0] rise;
  logic         flag_q, flag_n;

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end

  always_comb begin
    flag_n = flag_q;
    if (|rise)    flag_n = 1'b1;
    else if (clr) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      lvl_q  <= lvl;
      flag_q <= flag_n;
    end
  end

  assign flag = flag_q;

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> flag);
  p_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !(|rise) |=> !flag);
endmodule

// File: rtl/usb_bus_monitor.sv
module usb_bus_monitor
  import usb_mon_pkg::*;
#(
  parameter int CLK_PER_BIT = 4,
  parameter int TOUT_BITS   = 18,
  parameter int RST_CYC     = 120,
  parameter int SUSP_CYC    = 144000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_i,
  input  logic       pkt_end,
  input  logic       irq_en,
  input  logic       flag_clr,
  input  logic       rwake,
  input  logic       force_se0,
  output logic [3:0] status,
  output logic       evt_flag,
  output logic       irq,
  output logic       drive_k,
  output logic       drive_se0
);
  localparam int TOUT_CYC = CLK_PER_BIT * TOUT_BITS;

  logic     srst_n;
  line_e    line_q;
  logic     se0_hit, idle_hit, ta_hit;
  logic     armed_q, armed_n;
  logic     resume_q, resume_n;
  logic     tout_q, tout_n;
  logic     susp_q;
  logic     drv_k_q, drv_se0_q;
  bus_sts_t sts;

  usb_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  usb_run_timer #(.LIMIT(RST_CYC)) u_se0_tmr (
    .clk(clk), .rst_n(srst_n), .run(line_q == LS_SE0), .restart(1'b0),
    .hit(se0_hit)
  );

  usb_run_timer #(.LIMIT(SUSP_CYC)) u_idle_tmr (
    .clk(clk), .rst_n(srst_n), .run(line_q == LS_J), .restart(1'b0),
    .hit(idle_hit)
  );

  usb_run_timer #(.LIMIT(TOUT_CYC)) u_ta_tmr (
    .clk(clk), .rst_n(srst_n), .run(armed_q), .restart(pkt_end),
    .hit(ta_hit)
  );

  always_comb begin
    armed_n = armed_q;
    if (pkt_end)                        armed_n = 1'b1;
    else if (line_q != LS_J || ta_hit)  armed_n = 1'b0;

    tout_n = tout_q;
    if (pkt_end)     tout_n = 1'b0;
    else if (ta_hit) tout_n = 1'b1;

    resume_n = resume_q;
    if (susp_q && !idle_hit)                  resume_n = 1'b1;
    else if ((idle_hit && !susp_q) || se0_hit) resume_n = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      line_q    <= LS_K;
      armed_q   <= 1'b0;
      tout_q    <= 1'b0;
      resume_q  <= 1'b0;
      susp_q    <= 1'b0;
      drv_k_q   <= 1'b0;
      drv_se0_q <= 1'b0;
    end else begin
      line_q    <= line_e'(line_i);
      armed_q   <= armed_n;
      tout_q    <= tout_n;
      resume_q  <= resume_n;
      susp_q    <= idle_hit;
      drv_k_q   <= rwake & ~force_se0;
      drv_se0_q <= force_se0;
    end
  end

  always_comb begin
    sts.bus_rst = se0_hit;
    sts.suspend = idle_hit;
    sts.resume  = resume_q;
    sts.tout    = tout_q;
  end

  usb_evt_flag #(.N(NUM_EVT)) u_flag (
    .clk(clk), .rst_n(srst_n), .lvl(sts), .clr(flag_clr), .flag(evt_flag)
  );

  assign status    = sts;
  assign irq       = evt_flag & irq_en;
  assign drive_k   = drv_k_q;
  assign drive_se0 = drv_se0_q;

  p_susp_drop_r2: assert property (@(posedge clk) disable iff (!srst_n)
    idle_hit && line_q != LS_J |=> !status[1]);
  p_resume_on_wake_r3: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(idle_hit) |=> status[2]);
  p_tout_clear_r4: assert property (@(posedge clk) disable iff (!srst_n)
    pkt_end |=> !status[3]);
  p_rst_not_idle_r1: assert property (@(posedge clk) disable iff (!srst_n)
    !(status[0] && status[1]));
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> irq_en);
  p_drive_excl_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !(drive_k && drive_se0));
  p_drive_k_r8: assert property (@(posedge clk) disable iff (!srst_n)
    rwake && !force_se0 |=> drive_k);
endmodule

// File: tb/sim_usb_bus_monitor.sv
module sim_usb_bus_monitor;
  localparam int CPB = 2, TBITS = 18, RSTC = 10, SUSPC = 80;
  localparam int TOUTC = CPB * TBITS;
  // {rwake, force_se0, exp_k, exp_se0}
  localparam logic [3:0] DRV_TAB [4] = '{4'b0000, 4'b1010, 4'b0101, 4'b1101};

  logic clk = 1'b0;
  logic rst_n, pkt_end, irq_en, flag_clr, rwake, force_se0;
  logic [1:0] line_i;
  logic [3:0] status;
  logic evt_flag, irq, drive_k, drive_se0;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usb_bus_monitor #(.CLK_PER_BIT(CPB), .TOUT_BITS(TBITS), .RST_CYC(RSTC),
                    .SUSP_CYC(SUSPC)) u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .pkt_end(pkt_end),
    .irq_en(irq_en), .flag_clr(flag_clr), .rwake(rwake),
    .force_se0(force_se0), .status(status), .evt_flag(evt_flag), .irq(irq),
    .drive_k(drive_k), .drive_se0(drive_se0)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; step(1); flag_clr = 1'b0; step(1);
  endtask

  initial begin
    rst_n = 1'b0; line_i = 2'b10; pkt_end = 1'b0; irq_en = 1'b1;
    flag_clr = 1'b0; rwake = 1'b0; force_se0 = 1'b0;
    step(3); rst_n = 1'b1; step(4);
    chk("R10", "status", status, 4'h0);
    chk("R10", "flag", evt_flag, 0);
    chk("R10", "irq", irq, 0);
    chk("R10", "drives", {drive_k, drive_se0}, 2'b00);

    for (int i = 0; i < 4; i++) begin
      {rwake, force_se0} = DRV_TAB[i][3:2];
      step(2);
      chk("R8", "drive_k", drive_k, DRV_TAB[i][1]);
      chk("R9", "drive_se0", drive_se0, DRV_TAB[i][0]);
    end
    rwake = 1'b0; force_se0 = 1'b0; step(2);

    // R1 bus reset threshold
    line_i = 2'b00; step(RSTC - 3);
    chk("R1", "reset early", status[0], 0);
    step(8);
    chk("R1", "reset set", status[0], 1);
    chk("R5", "flag on reset", evt_flag, 1);
    line_i = 2'b01; step(3);
    chk("R1", "reset released", status[0], 0);
    chk("R5", "flag sticky", evt_flag, 1);
    clear_flag();
    chk("R6", "flag cleared", evt_flag, 0);

    // R2 suspend after long J
    step(SUSPC + 5);
    chk("R2", "suspend set", status[1], 1);
    chk("R5", "flag on suspend", evt_flag, 1);
    irq_en = 1'b0; step(1);
    chk("R7", "irq masked", irq, 0);
    irq_en = 1'b1; step(1);
    chk("R7", "irq enabled", irq, 1);
    clear_flag();
    chk("R6", "flag cleared", evt_flag, 0);
    chk("R6", "status kept", status[1], 1);
    chk("R7", "irq low after clear", irq, 0);

    // R3 resume
    line_i = 2'b10; step(5);
    chk("R2", "suspend dropped", status[1], 0);
    chk("R3", "resume set", status[2], 1);
    chk("R5", "flag on resume", evt_flag, 1);
    line_i = 2'b01; step(10);
    chk("R3", "resume held", status[2], 1);
    step(SUSPC);
    chk("R3", "resume cleared by suspend", status[2], 0);
    line_i = 2'b11; step(4);
    chk("R3", "resume after SE1", status[2], 1);
    clear_flag();

    // R4 turnaround timeout
    line_i = 2'b01; pkt_end = 1'b1; step(1); pkt_end = 1'b0;
    step(TOUTC - 4);
    chk("R4", "timeout early", status[3], 0);
    step(8);
    chk("R4", "timeout set", status[3], 1);
    chk("R5", "flag on timeout", evt_flag, 1);
    line_i = 2'b10; step(2); clear_flag();
    line_i = 2'b01; pkt_end = 1'b1; step(1); pkt_end = 1'b0; step(1);
    chk("R4", "timeout cleared", status[3], 0);
    step(10); line_i = 2'b10; step(2); line_i = 2'b01;
    step(TOUTC + 4);
    chk("R4", "answered no timeout", status[3], 0);
    chk("R6", "no new flag", evt_flag, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule